// File: doc/BRIEF.md
# Smart Card Activation Sequencer

This block is the digital controller for one smart card contact set. It filters two card-presence detector inputs, one active high and one active low. It reports through an active-low interrupt whether a usable card is seated. When the host pulls its session command low, the block raises the contact enables in a fixed order. The card supply comes first. The I/O and auxiliary data lines follow, but only once a supply-good input confirms that the card supply has settled. The card clock comes next, and the reset channel comes last.

Each session ends with the same steps in reverse order. Any of three events starts this shutdown: the host releases the command, the card is pulled out, or the chip supply drops into undervoltage. An undervoltage or a supply-good timeout also latches a fault that holds the interrupt low. The fault clears only when the host releases the command. When the host holds its reset input high as the session starts, the block holds the clock back until that input falls. The host can then count clock pulses before it lets the card out of reset.

The regulator, the charge pump and the comparators sit outside the block. Their results arrive as the synchronous inputs `supply_ok_i` and `uv_i`. All timing values are counts of system-clock cycles, set by parameters.

Top module: `sc_seq_top`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, every enable output is 0 and `irq_n_o` is 0 (standby).
- R2: A card counts as present when `pres_hi_i`=1 or `pres_lo_n_i`=0. Each input is synchronised and must hold a new level for DEBOUNCE_CYCLES consecutive cycles before it is accepted, so a change shows DEBOUNCE_CYCLES+2 cycles after it is driven. A shorter pulse is ignored.
- R3: `irq_n_o` is 1 exactly when a debounced card is present and no fault is latched. Otherwise it is 0.
- R4: Activation raises `vcc_en_o`, then all bits of `data_en_o`, then `clk_en_o`, then `rst_en_o`. Each step comes STEP_CYCLES cycles after the one before it when nothing holds it back, and `vcc_en_o` rises one cycle after the command is seen low.
- R5: `data_en_o` rises only on a cycle when `supply_ok_i` was 1. If supply-good arrives after the step delay has already passed, the data lines rise one cycle later.
- R6: Activation starts only when all of these hold: a card is present, `cmd_n_i`=0, `uv_i`=0, and no fault is latched. After any deactivation, `cmd_n_i` must return to 1 before a new session can start.
- R7: When `cmd_n_i` goes to 1 during a session, `rst_en_o` falls one cycle later. `clk_en_o`, `data_en_o` and `vcc_en_o` then fall in that order, STEP_CYCLES apart.
- R8: `uv_i`=1 latches a fault and drops `irq_n_o` one cycle later. During a session it also starts deactivation. The fault clears only when the block is idle with `cmd_n_i`=1 and `uv_i`=0.
- R9: If `supply_ok_i` stays 0 for SUPPLY_TIMEOUT cycles after `vcc_en_o` rises, the block latches a fault and deactivates.
- R10: When the debounced card disappears during a session, deactivation starts at once, without waiting for the host command.
- R11: If `rstin_i`=1 when the session starts, `clk_en_o` stays 0 after the data lines rise until `rstin_i` is 0. The clock then rises one cycle later, and `rst_en_o` follows STEP_CYCLES after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pres_hi_i | input | 1 | Presence detector, high when a card is seated |
| pres_lo_n_i | input | 1 | Presence detector, low when a card is seated |
| cmd_n_i | input | 1 | Host session command, low requests activation |
| rstin_i | input | 1 | Host reset input, high at session start selects held-clock mode |
| supply_ok_i | input | 1 | Card supply has reached its programmed level |
| uv_i | input | 1 | Chip supply undervoltage |
| vcc_en_o | output | 1 | Card supply enable |
| data_en_o | output | NUM_DATA | I/O and auxiliary line enables |
| clk_en_o | output | 1 | Card clock enable |
| rst_en_o | output | 1 | Card reset channel enable |
| irq_n_o | output | 1 | Active-low card-present interrupt |

## Verification
Each result has a fixed latency:
- A presence change reaches `irq_n_o` DEBOUNCE_CYCLES+2 cycles after it is driven.
- `vcc_en_o` rises one cycle after the command is seen low, and every later enable rises STEP_CYCLES after the previous one.
- A late supply-good, or the fall of the host reset input in held-clock mode, releases the next enable after one cycle.
- On release or undervoltage, the reset enable falls after one cycle and the other enables fall STEP_CYCLES apart.
- Undervoltage pulls the interrupt low after one cycle.

The bench drives inputs on the falling clock edge and counts whole cycles to each output change, checking those counts against the figures above. Its table of vectors waits well past the longest settling time before it compares the outputs.

// File: rtl/sc_seq_pkg.sv
// Package: shared types for the smart card activation sequencer.
// Assumes: one sequencer per card slot; all timing in system-clock cycles.
package sc_seq_pkg;

    // Number of presence detector inputs (one active-high, one active-low)
    localparam int unsigned NUM_PRES = 2;

    // Sequencer states: activation ramp, session, reverse ramp, release wait
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VCC,
        ST_IO,
        ST_CLK,
        ST_ACT,
        ST_D_RST,
        ST_D_CLK,
        ST_D_IO,
        ST_REL
    } seq_state_e;

    // Contact enable set driven by the sequencer
    typedef struct packed {
        logic vcc;
        logic io;
        logic clk;
        logic rst;
    } card_en_t;

endpackage

// File: rtl/sc_seq_debounce.sv
// Module: two-flop synchroniser followed by a stability filter.
// What it does: stable_o takes a new level only after the synchronised
// input has differed from it for DEB_CYCLES consecutive cycles.
// Assumes: DEB_CYCLES >= 1; the reset level is 0 (no card).
module sc_seq_debounce #(
    parameter int unsigned DEB_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic stable_o
);
    localparam int unsigned CW = $clog2(DEB_CYCLES + 1);

    logic [1:0]    sync_q;
    logic          stable_q;
    logic [CW-1:0] cnt_q;

    // Bring the asynchronous detector level into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], raw_i};
    end

    // Count cycles of disagreement and accept the level once the count is reached
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b0;
            cnt_q    <= '0;
        end else if (sync_q[1] == stable_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
            stable_q <= sync_q[1];
            cnt_q    <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stable_o = stable_q;

endmodule

// File: rtl/sc_seq_fsm.sv
// Module: activation / deactivation state machine with step timer and fault latch.
// What it does: ramps contact enables up in the order supply, data, clock,
// reset, and down in the reverse order, with STEP_CYCLES between steps.
// Assumes: present_i is already debounced; supply_ok_i and uv_i are synchronous;
// SUPPLY_TIMEOUT > STEP_CYCLES >= 1.
module sc_seq_fsm
    import sc_seq_pkg::*;
#(
    parameter int unsigned STEP_CYCLES    = 8,
    parameter int unsigned SUPPLY_TIMEOUT = 40
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     present_i,
    input  logic     cmd_n_i,
    input  logic     rstin_i,
    input  logic     supply_ok_i,
    input  logic     uv_i,
    output card_en_t en_o,
    output logic     fault_o,
    output logic     hold_o
);
    localparam int unsigned MAXC = (STEP_CYCLES > SUPPLY_TIMEOUT) ? STEP_CYCLES : SUPPLY_TIMEOUT;
    localparam int unsigned CW   = $clog2(MAXC + 1);

    seq_state_e    state_q, state_d;
    card_en_t      en_q, en_d;
    logic [CW-1:0] cnt_q;
    logic          hold_q, fault_q;
    logic          abort, step_done, tmo_hit, start;

    // Session-ending conditions and timer decodes
    always_comb begin
        abort     = cmd_n_i | ~present_i | uv_i;
        step_done = (cnt_q >= CW'(STEP_CYCLES - 1));
        tmo_hit   = (state_q == ST_VCC) && !supply_ok_i && (cnt_q >= CW'(SUPPLY_TIMEOUT - 1));
        start     = (state_q == ST_IDLE) && present_i && !cmd_n_i && !uv_i && !fault_q;
    end

    // Next-state and next-enable decode
    always_comb begin
        state_d = state_q;
        en_d    = en_q;
        unique case (state_q)
            ST_IDLE: begin
                en_d = '0;
                if (start) begin
                    state_d = ST_VCC;
                    en_d.vcc = 1'b1;
                end
            end
            ST_VCC: begin
                if (abort || tmo_hit) begin
                    state_d = ST_D_RST;
                    en_d.rst = 1'b0;
                end else if (step_done && supply_ok_i) begin
                    state_d = ST_IO;
                    en_d.io = 1'b1;
                end
            end
            ST_IO: begin
                if (abort) begin
                    state_d = ST_D_RST;
                    en_d.rst = 1'b0;
                end else if (step_done && !(hold_q && rstin_i)) begin
                    state_d = ST_CLK;
                    en_d.clk = 1'b1;
                end
            end
            ST_CLK: begin
                if (abort) begin
                    state_d = ST_D_RST;
                    en_d.rst = 1'b0;
                end else if (step_done) begin
                    state_d = ST_ACT;
                    en_d.rst = 1'b1;
                end
            end
            ST_ACT: begin
                if (abort) begin
                    state_d = ST_D_RST;
                    en_d.rst = 1'b0;
                end
            end
            ST_D_RST: begin
                if (step_done) begin
                    state_d = ST_D_CLK;
                    en_d.clk = 1'b0;
                end
            end
            ST_D_CLK: begin
                if (step_done) begin
                    state_d = ST_D_IO;
                    en_d.io = 1'b0;
                end
            end
            ST_D_IO: begin
                if (step_done) begin
                    state_d = ST_REL;
                    en_d.vcc = 1'b0;
                end
            end
            ST_REL: begin
                if (cmd_n_i) state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                en_d    = '0;
            end
        endcase
    end

    // State and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            en_q    <= '0;
        end else begin
            state_q <= state_d;
            en_q    <= en_d;
        end
    end

    // Step timer: restarts on each state change, saturates otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt_q <= '0;
        else if (state_d != state_q)        cnt_q <= '0;
        else if (cnt_q != {CW{1'b1}})       cnt_q <= cnt_q + 1'b1;
    end

    // Capture held-clock mode from the host reset input at session start
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_q <= 1'b0;
        else if (start) hold_q <= rstin_i;
    end

    // Fault latch: set by undervoltage or supply timeout, cleared on host release while idle
    always_ff @(posedge clk) begin
        if (!rst_n)                                   fault_q <= 1'b0;
        else if (uv_i || tmo_hit)                     fault_q <= 1'b1;
        else if (state_q == ST_IDLE && cmd_n_i)       fault_q <= 1'b0;
    end

    assign en_o    = en_q;
    assign fault_o = fault_q;
    assign hold_o  = hold_q;

endmodule

// File: rtl/sc_seq_top.sv
// Module: smart card activation sequencer top level.
// What it does: debounces both presence detectors, runs the contact
// sequencer and drives the active-low presence interrupt.
// Assumes: all inputs except the presence detectors are synchronous to clk.
module sc_seq_top
    import sc_seq_pkg::*;
#(
    parameter int unsigned DEBOUNCE_CYCLES = 2_000_000,
    parameter int unsigned STEP_CYCLES     = 250,
    parameter int unsigned SUPPLY_TIMEOUT  = 25_000_000,
    parameter int unsigned NUM_DATA        = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pres_hi_i,
    input  logic                pres_lo_n_i,
    input  logic                cmd_n_i,
    input  logic                rstin_i,
    input  logic                supply_ok_i,
    input  logic                uv_i,
    output logic                vcc_en_o,
    output logic [NUM_DATA-1:0] data_en_o,
    output logic                clk_en_o,
    output logic                rst_en_o,
    output logic                irq_n_o
);
    logic [NUM_PRES-1:0] raw_pres;
    logic [NUM_PRES-1:0] stable_pres;
    logic                pres_db;
    logic                fault_w;
    logic                hold_w;
    card_en_t            en_w;

    // Normalise both detectors to "1 = card seated"
    assign raw_pres[0] = pres_hi_i;
    assign raw_pres[1] = ~pres_lo_n_i;

    // One filter per detector input
    for (genvar g = 0; g < NUM_PRES; g++) begin : g_deb
        sc_seq_debounce #(
            .DEB_CYCLES(DEBOUNCE_CYCLES)
        ) u_deb (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_i    (raw_pres[g]),
            .stable_o (stable_pres[g])
        );
    end

    assign pres_db = |stable_pres;

    sc_seq_fsm #(
        .STEP_CYCLES    (STEP_CYCLES),
        .SUPPLY_TIMEOUT (SUPPLY_TIMEOUT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .present_i   (pres_db),
        .cmd_n_i     (cmd_n_i),
        .rstin_i     (rstin_i),
        .supply_ok_i (supply_ok_i),
        .uv_i        (uv_i),
        .en_o        (en_w),
        .fault_o     (fault_w),
        .hold_o      (hold_w)
    );

    // Contact enables and interrupt
    assign vcc_en_o  = en_w.vcc;
    assign data_en_o = {NUM_DATA{en_w.io}};
    assign clk_en_o  = en_w.clk;
    assign rst_en_o  = en_w.rst;
    assign irq_n_o   = pres_db & ~fault_w;

endmodule

// File: rtl/sc_seq_chk.sv
// Module: property checker for sc_seq_top, attached by bind.
// Assumes: sampled on the rising clock; properties are off while rst_n is low.
module sc_seq_chk #(
    parameter int unsigned NUM_DATA = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_n_i,
    input logic                rstin_i,
    input logic                supply_ok_i,
    input logic                uv_i,
    input logic                present,
    input logic                hold,
    input logic                vcc_en,
    input logic [NUM_DATA-1:0] data_en,
    input logic                clk_en,
    input logic                rst_en,
    input logic                irq_n
);
    // R1: standby after reset
    p_standby_r1: assert property (@(posedge clk)
        !rst_n |=> (!vcc_en && data_en == '0 && !clk_en && !rst_en && !irq_n));

    // R4: ordering of enables
    p_data_needs_vcc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|data_en) |-> vcc_en);
    p_clk_needs_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> (&data_en));
    p_rst_needs_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_en |-> clk_en);

    // R5: data lines come up only with supply good
    p_data_needs_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_en[0]) |-> $past(supply_ok_i));

    // R6: session start conditions
    p_start_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vcc_en) |-> ($past(present) && !$past(cmd_n_i) && !$past(uv_i)));

    // R7: host release drops reset first
    p_release_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_n_i |=> !rst_en);

    // R8: undervoltage pulls interrupt and reset low
    p_uv_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |=> !irq_n);
    p_uv_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |=> !rst_en);

    // R10: card loss ends the session
    p_removal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !present |=> !rst_en);

    // R11: held-clock mode waits for the host reset input to fall
    p_hold_clk_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(clk_en) && hold) |-> !$past(rstin_i));

endmodule

bind sc_seq_top sc_seq_chk #(.NUM_DATA(NUM_DATA)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_n_i     (cmd_n_i),
    .rstin_i     (rstin_i),
    .supply_ok_i (supply_ok_i),
    .uv_i        (uv_i),
    .present     (pres_db),
    .hold        (hold_w),
    .vcc_en      (vcc_en_o),
    .data_en     (data_en_o),
    .clk_en      (clk_en_o),
    .rst_en      (rst_en_o),
    .irq_n       (irq_n_o)
);

// File: tb/sim_sc_seq_top.sv
// Bench: vector table walk followed by directed timing and corner tests.
module sim_sc_seq_top;
    localparam int unsigned DEB  = 16;
    localparam int unsigned STEP = 8;
    localparam int unsigned TMO  = 40;
    localparam int unsigned ND   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pres_hi = 1'b0, pres_lo_n = 1'b1, cmd_n = 1'b1, rstin = 1'b0, ok = 1'b0, uv = 1'b0;
    logic          vcc_en, clk_en, rst_en, irq_n;
    logic [ND-1:0] data_en;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    sc_seq_top #(
        .DEBOUNCE_CYCLES (DEB),
        .STEP_CYCLES     (STEP),
        .SUPPLY_TIMEOUT  (TMO),
        .NUM_DATA        (ND)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pres_hi_i   (pres_hi),
        .pres_lo_n_i (pres_lo_n),
        .cmd_n_i     (cmd_n),
        .rstin_i     (rstin),
        .supply_ok_i (ok),
        .uv_i        (uv),
        .vcc_en_o    (vcc_en),
        .data_en_o   (data_en),
        .clk_en_o    (clk_en),
        .rst_en_o    (rst_en),
        .irq_n_o     (irq_n)
    );

    // Vector: {pres_hi, pres_lo_n, cmd_n, rstin, ok, uv, wait[7:0], exp vcc,io,clk,rst,irq_n}
    localparam logic [18:0] VEC [13] = '{
        {6'b011000, 8'd30,  5'b00000},  // R1 R3: no card, idle
        {6'b111000, 8'd30,  5'b00001},  // R2 R3: high detector seats card
        {6'b110010, 8'd60,  5'b11111},  // R4 R6: full activation
        {6'b111010, 8'd60,  5'b00001},  // R7: host release
        {6'b001010, 8'd30,  5'b00001},  // R2: low detector seats card
        {6'b000010, 8'd60,  5'b11111},  // R4: activation again
        {6'b000011, 8'd60,  5'b00000},  // R8: undervoltage deactivates
        {6'b000010, 8'd60,  5'b00000},  // R6 R8: no restart without release
        {6'b001010, 8'd10,  5'b00001},  // R8: release clears fault
        {6'b000000, 8'd100, 5'b00000},  // R9: supply-good timeout
        {6'b001010, 8'd10,  5'b00001},  // R9: release clears fault
        {6'b000010, 8'd60,  5'b11111},  // R4: activation
        {6'b010010, 8'd60,  5'b00000}   // R10: card removal
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic out_sel(input int idx);
        case (idx)
            0:       out_sel = vcc_en;
            1:       out_sel = data_en[0];
            2:       out_sel = clk_en;
            3:       out_sel = rst_en;
            default: out_sel = irq_n;
        endcase
    endfunction

    // Count falling edges until the selected output reaches lvl (capped)
    task automatic measure(input int idx, input logic lvl, output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            n++;
            if (out_sel(idx) == lvl) break;
        end
    endtask

    initial begin
        int n;
        logic [6:0] got, want;
        // R1: reset state
        tick(3);
        check("R1 reset outputs", {vcc_en, data_en, clk_en, rst_en, irq_n}, 7'b0);
        rst_n = 1'b1;
        tick(1);
        check("R1 standby after reset", {vcc_en, data_en, clk_en, rst_en, irq_n}, 7'b0);

        // Table walk
        for (int v = 0; v < 13; v++) begin
            pres_hi   = VEC[v][18];
            pres_lo_n = VEC[v][17];
            cmd_n     = VEC[v][16];
            rstin     = VEC[v][15];
            ok        = VEC[v][14];
            uv        = VEC[v][13];
            tick(int'(VEC[v][12:5]));
            got  = {vcc_en, data_en, clk_en, rst_en, irq_n};
            want = {VEC[v][4], {ND{VEC[v][3]}}, VEC[v][2], VEC[v][1], VEC[v][0]};
            checks++;
            if (got !== want) begin
                errors++;
                $display("FAIL vector %0d (R1..R10 table) actual=%b expected=%b", v, got, want);
            end
        end

        // R2: short glitch ignored, then exact debounce latency
        cmd_n = 1'b1;
        pres_hi = 1'b1; tick(10); pres_hi = 1'b0; tick(30);
        check("R2 glitch ignored", irq_n, 1'b0);
        pres_hi = 1'b1;
        measure(4, 1'b1, n);
        check("R2 debounce latency", n, DEB + 2);

        // R5: data waits for supply good; R4: spacing of later steps
        ok = 1'b0; cmd_n = 1'b0;
        measure(0, 1'b1, n);
        check("R6 supply on one cycle after command", n, 1);
        tick(20);
        check("R5 data held without supply good", data_en, 3'b000);
        ok = 1'b1;
        measure(1, 1'b1, n);
        check("R5 data one cycle after late supply good", n, 1);
        measure(2, 1'b1, n);
        check("R4 clock after data", n, STEP);
        measure(3, 1'b1, n);
        check("R4 reset after clock", n, STEP);

        // R7: reverse order on release
        cmd_n = 1'b1;
        measure(3, 1'b0, n);
        check("R7 reset falls first", n, 1);
        measure(2, 1'b0, n);
        check("R7 clock falls after reset", n, STEP);
        measure(1, 1'b0, n);
        check("R7 data falls after clock", n, STEP);
        measure(0, 1'b0, n);
        check("R7 supply falls after data", n, STEP);

        // R4: supply to data spacing with supply good already present
        tick(5); cmd_n = 1'b0;
        measure(0, 1'b1, n);
        check("R4 supply rises", n, 1);
        measure(1, 1'b1, n);
        check("R4 data after supply", n, STEP);
        cmd_n = 1'b1; tick(40);

        // R11: held-clock mode
        rstin = 1'b1; tick(1); cmd_n = 1'b0; tick(60);
        check("R11 data up while held", data_en, 3'b111);
        check("R11 clock held", {clk_en, rst_en}, 2'b00);
        rstin = 1'b0;
        measure(2, 1'b1, n);
        check("R11 clock after host reset falls", n, 1);
        measure(3, 1'b1, n);
        check("R11 reset after clock", n, STEP);
        cmd_n = 1'b1; tick(40);

        // R8 and R6: undervoltage while idle
        uv = 1'b1;
        measure(4, 1'b0, n);
        check("R8 interrupt low after undervoltage", n, 1);
        cmd_n = 1'b0; tick(30);
        check("R6 no start under undervoltage", vcc_en, 1'b0);
        uv = 1'b0; tick(30);
        check("R8 fault holds without release", {vcc_en, irq_n}, 2'b00);
        cmd_n = 1'b1; tick(3);
        check("R8 release clears fault", irq_n, 1'b1);

        // R6 and R3: no card
        pres_hi = 1'b0; tick(30);
        check("R3 interrupt low without card", irq_n, 1'b0);
        cmd_n = 1'b0; tick(30);
        check("R6 no start without card", vcc_en, 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule